// File: doc/BRIEF.md
# Memory-to-Memory DMA Copy Engine

A single-channel engine that copies a block of 32-bit words from one memory region to another without processor help. Software fills three configuration registers (source address, destination address, byte count) through a small memory-mapped register port, then sets the start bit. The engine takes over the bus for each beat. It asks for the read bus and waits for the grant. It issues a read command and waits, for as long as needed, for the returned word. It then asks for the write bus, issues the write with that word and waits for the write response. Both addresses then advance by one word and the next beat begins.

Reads and writes leave through two separate master ports, each with its own request/grant pair. The command phase of each port is valid/ready. While `*_valid` is high and `*_ready` is low, the engine holds valid, address and data unchanged. The transfer happens on the first clock edge where both are high. A responder returns exactly one response per accepted command on the `*_rvalid` / `*_bvalid` pulse. The engine accepts that pulse in any cycle, so the response channels carry no ready.

At the end of a job, or when a job stops early, the engine sets a sticky done flag, records whether the job failed, and raises an interrupt when that is enabled. Only one job runs at a time. While a job is running, configuration writes and further start requests are ignored.

Top module: `dma_copy_engine`

## Requirements
- R1: Register offsets are 0x00 source, 0x04 destination, 0x08 byte count, 0x0C control (bit0 start, bit1 interrupt enable) and 0x10 status (bit0 busy, bit1 done, bit2 error). After reset every register reads zero, `irq` is low and neither bus request is high.
- R2: After a start, `rd_bus_req` rises and no read command (`rd_valid`) is issued before `rd_bus_gnt` has been seen high.
- R3: A read command holds `rd_valid` and `rd_addr` steady until `rd_ready`. The engine then waits any number of cycles for `rd_rvalid` before it moves on.
- R4: A write command holds `wr_valid`, `wr_addr` and `wr_wdata` steady until `wr_ready`. The next beat starts only after `wr_bvalid`.
- R5: A job of N bytes performs N/4 beats. Beat i reads source+4i and writes the word returned by that read to destination+4i.
- R6: `rd_bus_req` and `wr_bus_req` are never high together. The read of each beat completes before its write is issued.
- R7: On completion busy drops, done is set, error stays clear, and `irq` equals done AND interrupt enable.
- R8: A byte count of zero, a count that is not a multiple of 4, or a source or destination address that is not 4-byte aligned ends the job at once with done and error set and no bus request.
- R9: A read or write error response stops the job after that beat. No further command is issued, and done and error are set.
- R10: While busy, writes to the source, destination and count registers and start requests have no effect.
- R11: Writing 1 to status bit1 clears done, error and `irq`. If that write lands in the same cycle as the engine records completion, completion wins and done stays set.
- R12: Accepting a new start clears done and error from the previous job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| irq | output | 1 | Completion interrupt, level |
| rd_bus_req | output | 1 | Read master bus request |
| rd_bus_gnt | input | 1 | Read master bus grant |
| rd_valid | output | 1 | Read command valid |
| rd_ready | input | 1 | Read command accepted |
| rd_addr | output | 32 | Read word address |
| rd_rvalid | input | 1 | Read data returned |
| rd_rdata | input | 32 | Returned read word |
| rd_rerr | input | 1 | Read response is an error |
| wr_bus_req | output | 1 | Write master bus request |
| wr_bus_gnt | input | 1 | Write master bus grant |
| wr_valid | output | 1 | Write command valid |
| wr_ready | input | 1 | Write command accepted |
| wr_addr | output | 32 | Write word address |
| wr_wdata | output | 32 | Write data word |
| wr_bvalid | input | 1 | Write response returned |
| wr_berr | input | 1 | Write response is an error |

## Verification
Two things can fall on the same clock edge: the engine recording completion in its final state, and a software write that clears done. The bench provokes this by reading status every cycle during a job and writing the clear bit in every cycle that busy still reads high. Its last clear therefore lands exactly on the completion edge. Once busy drops, the test passes only if done still reads 1 and `irq` is high. Separately, sweeps over beat count, grant delay, read latency and ready stalls cover the ordering of read and write phases.

// File: rtl/dma_copy_pkg.sv
package dma_copy_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_RD,
    ST_READ_WAIT,
    ST_REQ_WR,
    ST_WRITE_WAIT,
    ST_NEXT,
    ST_DONE
  } dma_state_e;

  localparam int unsigned REG_DW = 32;
  localparam int unsigned REG_AW = 5;

  localparam logic [2:0] SLOT_SRC  = 3'd0;
  localparam logic [2:0] SLOT_DST  = 3'd1;
  localparam logic [2:0] SLOT_CNT  = 3'd2;
  localparam logic [2:0] SLOT_CTRL = 3'd3;
  localparam logic [2:0] SLOT_STAT = 3'd4;

  localparam int unsigned CTRL_GO_BIT   = 0;
  localparam int unsigned CTRL_IEN_BIT  = 1;
  localparam int unsigned STAT_BUSY_BIT = 0;
  localparam int unsigned STAT_DONE_BIT = 1;
  localparam int unsigned STAT_ERR_BIT  = 2;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_copy_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              busy,
  input  logic              done_pulse,
  input  logic              eng_err,
  output logic [AW-1:0]     cfg_src,
  output logic [AW-1:0]     cfg_dst,
  output logic [CNT_W-1:0]  cfg_cnt,
  output logic              start,
  output logic              irq
);

  logic [AW-1:0]    src_q, dst_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ien_q, done_q, err_q;
  logic             hit;
  logic [2:0]       slot;
  logic             clr_req;

  assign slot    = reg_addr[4:2];
  assign hit     = (reg_addr[1:0] == 2'b00);
  assign start   = reg_wr && hit && (slot == SLOT_CTRL) && reg_wdata[CTRL_GO_BIT] && !busy;
  assign clr_req = reg_wr && hit && (slot == SLOT_STAT) && reg_wdata[STAT_DONE_BIT];

  // configuration registers, frozen while a job runs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      ien_q <= 1'b0;
    end else if (reg_wr && hit) begin
      if (!busy && slot == SLOT_SRC) src_q <= reg_wdata[AW-1:0];
      if (!busy && slot == SLOT_DST) dst_q <= reg_wdata[AW-1:0];
      if (!busy && slot == SLOT_CNT) cnt_q <= reg_wdata[CNT_W-1:0];
      if (slot == SLOT_CTRL)         ien_q <= reg_wdata[CTRL_IEN_BIT];
    end
  end

  // sticky completion flags; engine completion outranks a software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (start) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (done_pulse) begin
      done_q <= 1'b1;
      err_q  <= eng_err;
    end else if (clr_req) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit) begin
      unique case (slot)
        SLOT_SRC:  reg_rdata = REG_DW'(src_q);
        SLOT_DST:  reg_rdata = REG_DW'(dst_q);
        SLOT_CNT:  reg_rdata = REG_DW'(cnt_q);
        SLOT_CTRL: reg_rdata[CTRL_IEN_BIT] = ien_q;
        SLOT_STAT: begin
          reg_rdata[STAT_BUSY_BIT] = busy;
          reg_rdata[STAT_DONE_BIT] = done_q;
          reg_rdata[STAT_ERR_BIT]  = err_q;
        end
        default:   reg_rdata = '0;
      endcase
    end
  end

  assign cfg_src = src_q;
  assign cfg_dst = dst_q;
  assign cfg_cnt = cnt_q;
  assign irq     = done_q & ien_q;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_wr |=> $stable(src_q) && $stable(dst_q) && $stable(cnt_q)); // R10
  AST_DONE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> done_q); // R11
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done_q && !err_q); // R12

endmodule

// File: rtl/dma_copy_seq.sv
module dma_copy_seq
  import dma_copy_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    cfg_src,
  input  logic [AW-1:0]    cfg_dst,
  input  logic [CNT_W-1:0] cfg_cnt,
  output logic             busy,
  output logic             done_pulse,
  output logic             eng_err,
  output logic             rd_bus_req,
  input  logic             rd_bus_gnt,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [AW-1:0]    rd_addr,
  input  logic             rd_rvalid,
  input  logic [DW-1:0]    rd_rdata,
  input  logic             rd_rerr,
  output logic             wr_bus_req,
  input  logic             wr_bus_gnt,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [AW-1:0]    wr_addr,
  output logic [DW-1:0]    wr_wdata,
  input  logic             wr_bvalid,
  input  logic             wr_berr
);

  localparam int unsigned BEAT_BYTES = DW / 8;
  localparam int unsigned ALIGN_BITS = $clog2(BEAT_BYTES);
  localparam logic [AW-1:0]    STEP     = AW'(BEAT_BYTES);
  localparam logic [CNT_W-1:0] ONE_BEAT = CNT_W'(1);

  dma_state_e       state_q;
  logic [AW-1:0]    src_q, dst_q;
  logic [CNT_W-1:0] beats_q;
  logic [DW-1:0]    data_q;
  logic             sent_q;
  logic             err_q;
  logic             bad_cfg;

  assign bad_cfg = (cfg_cnt == '0)
                || (cfg_cnt[ALIGN_BITS-1:0] != '0)
                || (cfg_src[ALIGN_BITS-1:0] != '0)
                || (cfg_dst[ALIGN_BITS-1:0] != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      beats_q <= '0;
      data_q  <= '0;
      sent_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            sent_q <= 1'b0;
            if (bad_cfg) begin
              err_q   <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              err_q   <= 1'b0;
              src_q   <= cfg_src;
              dst_q   <= cfg_dst;
              beats_q <= cfg_cnt >> ALIGN_BITS;
              state_q <= ST_REQ_RD;
            end
          end
        end
        ST_REQ_RD: begin
          if (rd_bus_gnt) begin
            sent_q  <= 1'b0;
            state_q <= ST_READ_WAIT;
          end
        end
        ST_READ_WAIT: begin
          if (!sent_q && rd_ready) sent_q <= 1'b1;
          if (sent_q && rd_rvalid) begin
            data_q <= rd_rdata;
            if (rd_rerr) begin
              err_q   <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_REQ_WR;
            end
          end
        end
        ST_REQ_WR: begin
          if (wr_bus_gnt) begin
            sent_q  <= 1'b0;
            state_q <= ST_WRITE_WAIT;
          end
        end
        ST_WRITE_WAIT: begin
          if (!sent_q && wr_ready) sent_q <= 1'b1;
          if (sent_q && wr_bvalid) begin
            if (wr_berr) begin
              err_q   <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_NEXT;
            end
          end
        end
        ST_NEXT: begin
          src_q   <= src_q + STEP;
          dst_q   <= dst_q + STEP;
          beats_q <= beats_q - ONE_BEAT;
          state_q <= (beats_q == ONE_BEAT) ? ST_DONE : ST_REQ_RD;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done_pulse = (state_q == ST_DONE);
  assign eng_err    = err_q;

  assign rd_bus_req = (state_q == ST_REQ_RD) || (state_q == ST_READ_WAIT);
  assign rd_valid   = (state_q == ST_READ_WAIT) && !sent_q;
  assign rd_addr    = src_q;

  assign wr_bus_req = (state_q == ST_REQ_WR) || (state_q == ST_WRITE_WAIT);
  assign wr_valid   = (state_q == ST_WRITE_WAIT) && !sent_q;
  assign wr_addr    = dst_q;
  assign wr_wdata   = data_q;

  AST_RD_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(rd_bus_gnt)); // R2
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R3
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_wdata)); // R4
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_NEXT |=> rd_addr == $past(rd_addr) + STEP && wr_addr == $past(wr_addr) + STEP); // R5
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_bus_req && wr_bus_req)); // R6
  AST_BAD_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    start && cfg_cnt == '0 |=> done_pulse && !rd_bus_req); // R8
  AST_RERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_READ_WAIT && sent_q && rd_rvalid && rd_rerr |=> done_pulse && !wr_bus_req); // R9

endmodule

// File: rtl/dma_copy_engine.sv
module dma_copy_engine
  import dma_copy_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              irq,
  output logic              rd_bus_req,
  input  logic              rd_bus_gnt,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_rvalid,
  input  logic [DW-1:0]     rd_rdata,
  input  logic              rd_rerr,
  output logic              wr_bus_req,
  input  logic              wr_bus_gnt,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [AW-1:0]     wr_addr,
  output logic [DW-1:0]     wr_wdata,
  input  logic              wr_bvalid,
  input  logic              wr_berr
);

  logic [AW-1:0]    cfg_src, cfg_dst;
  logic [CNT_W-1:0] cfg_cnt;
  logic             start, busy, done_pulse, eng_err;

  dma_cfg_regs #(.AW(AW), .CNT_W(CNT_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .busy       (busy),
    .done_pulse (done_pulse),
    .eng_err    (eng_err),
    .cfg_src    (cfg_src),
    .cfg_dst    (cfg_dst),
    .cfg_cnt    (cfg_cnt),
    .start      (start),
    .irq        (irq)
  );

  dma_copy_seq #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cfg_src    (cfg_src),
    .cfg_dst    (cfg_dst),
    .cfg_cnt    (cfg_cnt),
    .busy       (busy),
    .done_pulse (done_pulse),
    .eng_err    (eng_err),
    .rd_bus_req (rd_bus_req),
    .rd_bus_gnt (rd_bus_gnt),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_addr    (rd_addr),
    .rd_rvalid  (rd_rvalid),
    .rd_rdata   (rd_rdata),
    .rd_rerr    (rd_rerr),
    .wr_bus_req (wr_bus_req),
    .wr_bus_gnt (wr_bus_gnt),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_addr    (wr_addr),
    .wr_wdata   (wr_wdata),
    .wr_bvalid  (wr_bvalid),
    .wr_berr    (wr_berr)
  );

  AST_IRQ_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bus_req |-> !irq); // R7

endmodule

// File: tb/dma_copy_engine_tb_top.sv
`timescale 1ns/1ps
module dma_copy_engine_tb_top;

  localparam logic [4:0] A_SRC = 5'h00, A_DST = 5'h04, A_CNT = 5'h08, A_CTRL = 5'h0C, A_STAT = 5'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        rd_bus_req, rd_valid, wr_bus_req, wr_valid;
  logic [31:0] rd_addr, wr_addr, wr_wdata;
  logic        rd_bus_gnt, rd_ready, rd_rvalid, rd_rerr;
  logic [31:0] rd_rdata;
  logic        wr_bus_gnt, wr_ready, wr_bvalid, wr_berr;

  always #4 clk = ~clk;

  dma_copy_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq),
    .rd_bus_req(rd_bus_req), .rd_bus_gnt(rd_bus_gnt), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata), .rd_rerr(rd_rerr),
    .wr_bus_req(wr_bus_req), .wr_bus_gnt(wr_bus_gnt), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_wdata(wr_wdata), .wr_bvalid(wr_bvalid), .wr_berr(wr_berr)
  );

  function automatic logic [31:0] src_word(input logic [31:0] a);
    return (a * 32'd2654435761) ^ 32'h5A5A1234;
  endfunction

  // configuration of the bus model (written by the main process only)
  int          gnt_dly = 0, lat = 0;
  bit          stall = 0;
  logic [31:0] err_rd_addr = '1, err_wr_addr = '1;
  logic [31:0] job_src = '0, job_dst = '0;
  int          base_rd = 0, base_wr = 0, base_bus = 0;
  // bus model state (written by the model only)
  int          n_rd = 0, n_wr = 0, bus_cyc = 0, m_checks = 0, m_errors = 0;
  // main process counters
  int          n_checks = 0, n_errors = 0;
  bit          wd_fail = 0;

  task automatic mchk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    m_checks++;
    if (!ok) begin
      m_errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // bus model: grants, ready stalls, response latency, error injection
  initial begin
    int cyc = 0, rg = 0, wg = 0, rl = 0, wl = 0;
    bit rpend = 0, wpend = 0, rprev_stall = 0, wprev_stall = 0;
    logic [31:0] rpaddr = '0, wpaddr = '0, rprev_addr = '0, wprev_addr = '0, wprev_data = '0;
    rd_bus_gnt = 0; rd_ready = 0; rd_rvalid = 0; rd_rdata = '0; rd_rerr = 0;
    wr_bus_gnt = 0; wr_ready = 0; wr_bvalid = 0; wr_berr = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rd_bus_req || wr_bus_req) bus_cyc++;
      if (rd_bus_req && wr_bus_req) mchk(0, "R6 overlap", 32'd1, 32'd0);
      if (rprev_stall && !(rd_valid && rd_addr == rprev_addr)) mchk(0, "R3 hold", rd_addr, rprev_addr);
      if (wprev_stall && !(wr_valid && wr_addr == wprev_addr && wr_wdata == wprev_data))
        mchk(0, "R4 hold", wr_wdata, wprev_data);
      // grants
      if (rd_bus_req) begin if (rg >= gnt_dly) rd_bus_gnt = 1; else rg++; end
      else begin rg = 0; rd_bus_gnt = 0; end
      if (wr_bus_req) begin if (wg >= gnt_dly) wr_bus_gnt = 1; else wg++; end
      else begin wg = 0; wr_bus_gnt = 0; end
      // read responses
      rd_rvalid = 0; rd_rerr = 0;
      if (rpend) begin
        if (rl == 0) begin
          rd_rvalid = 1; rd_rdata = src_word(rpaddr); rd_rerr = (rpaddr == err_rd_addr); rpend = 0;
        end else rl--;
      end
      rd_ready = stall ? (cyc % 3 != 0) : 1'b1;
      if (rd_valid && rd_ready) begin
        n_rd++;
        mchk(rd_bus_gnt, "R2 grant before read", {31'd0, rd_bus_gnt}, 32'd1);
        mchk(rd_addr == job_src + 32'(4 * (n_rd - base_rd - 1)), "R5 read addr",
             rd_addr, job_src + 32'(4 * (n_rd - base_rd - 1)));
        mchk(n_rd - base_rd == n_wr - base_wr + 1, "R6 read order", 32'(n_rd - base_rd), 32'(n_wr - base_wr + 1));
        rpend = 1; rl = lat; rpaddr = rd_addr;
      end
      rprev_stall = rd_valid && !rd_ready; rprev_addr = rd_addr;
      // write responses
      wr_bvalid = 0; wr_berr = 0;
      if (wpend) begin
        if (wl == 0) begin
          wr_bvalid = 1; wr_berr = (wpaddr == err_wr_addr); wpend = 0;
        end else wl--;
      end
      wr_ready = stall ? (cyc % 3 != 1) : 1'b1;
      if (wr_valid && wr_ready) begin
        n_wr++;
        mchk(wr_addr == job_dst + 32'(4 * (n_wr - base_wr - 1)), "R5 write addr",
             wr_addr, job_dst + 32'(4 * (n_wr - base_wr - 1)));
        mchk(wr_wdata == src_word(job_src + 32'(4 * (n_wr - base_wr - 1))), "R5 write data",
             wr_wdata, src_word(job_src + 32'(4 * (n_wr - base_wr - 1))));
        mchk(n_rd - base_rd == n_wr - base_wr, "R6 write after read", 32'(n_rd - base_rd), 32'(n_wr - base_wr));
        wpend = 1; wl = lat; wpaddr = wr_addr;
      end
      wprev_stall = wr_valid && !wr_ready; wprev_addr = wr_addr; wprev_data = wr_wdata;
    end
  end

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    int t = 0;
    reg_read(A_STAT, st);
    while (st[0] && t < 3000) begin
      @(negedge clk);
      t++;
      reg_read(A_STAT, st);
    end
    if (t >= 3000) chk(0, "R7 job timeout", 32'(t), 32'd0);
  endtask

  task automatic start_job(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c, input logic [31:0] ctrl);
    job_src = s; job_dst = d;
    base_rd = n_rd; base_wr = n_wr; base_bus = bus_cyc;
    reg_write(A_SRC, s);
    reg_write(A_DST, d);
    reg_write(A_CNT, c);
    reg_write(A_CTRL, ctrl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    wd_fail = 1;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", n_checks + m_checks + 1, n_errors + m_errors + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int job = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    reg_read(A_SRC, v);  chk(v == 0, "R1 src reset", v, 0);
    reg_read(A_DST, v);  chk(v == 0, "R1 dst reset", v, 0);
    reg_read(A_CNT, v);  chk(v == 0, "R1 cnt reset", v, 0);
    reg_read(A_CTRL, v); chk(v == 0, "R1 ctrl reset", v, 0);
    reg_read(A_STAT, v); chk(v == 0, "R1 stat reset", v, 0);
    chk(!irq && !rd_bus_req && !wr_bus_req, "R1 outputs reset", {29'd0, irq, rd_bus_req, wr_bus_req}, 0);
    reg_write(A_SRC, 32'h1234_5678);
    reg_read(A_SRC, v); chk(v == 32'h1234_5678, "R1 src readback", v, 32'h1234_5678);
    reg_write(A_CTRL, 32'h2);
    reg_read(A_CTRL, v); chk(v == 32'h2, "R1 ien readback", v, 32'h2);

    // R5 R7: sweep beats x grant delay x latency x stalls
    for (int nb = 1; nb <= 3; nb++)
      for (int g = 0; g <= 2; g++)
        for (int l = 0; l <= 3; l++)
          for (int s = 0; s <= 1; s++) begin
            gnt_dly = g; lat = l; stall = bit'(s);
            start_job(32'h1000 + 32'(16 * job), 32'h8000 + 32'(64 * job), 32'(4 * nb), 32'h3);
            wait_idle();
            reg_read(A_STAT, v);
            chk(v[2:0] == 3'b010, "R7 status done", v, 32'h2);
            chk(irq == 1'b1, "R7 irq", {31'd0, irq}, 1);
            chk(n_wr - base_wr == nb, "R5 beat count", 32'(n_wr - base_wr), 32'(nb));
            job++;
          end
    gnt_dly = 1; lat = 1; stall = 0;

    // R11: clear done
    reg_write(A_STAT, 32'h2);
    reg_read(A_STAT, v); chk(v[2:0] == 0, "R11 clear", v, 0);
    chk(irq == 0, "R11 irq cleared", {31'd0, irq}, 0);

    // R7: interrupt disabled
    start_job(32'h2000, 32'h9000, 32'd8, 32'h1);
    wait_idle();
    reg_read(A_STAT, v); chk(v[2:0] == 3'b010, "R7 done no ien", v, 2);
    chk(irq == 0, "R7 irq masked", {31'd0, irq}, 0);
    reg_write(A_CTRL, 32'h2);
    chk(irq == 1, "R7 irq on enable", {31'd0, irq}, 1);
    reg_write(A_STAT, 32'h2);

    // R8: illegal configurations
    for (int k = 0; k < 4; k++) begin
      logic [31:0] bs, bd, bc;
      bs = 32'h3000; bd = 32'hA000; bc = 32'd8;
      if (k == 0) bc = 0;
      if (k == 1) bc = 32'd6;
      if (k == 2) bs = 32'h3002;
      if (k == 3) bd = 32'hA001;
      start_job(bs, bd, bc, 32'h3);
      wait_idle();
      reg_read(A_STAT, v); chk(v[2:0] == 3'b110, "R8 error status", v, 6);
      chk(bus_cyc == base_bus, "R8 no bus", 32'(bus_cyc - base_bus), 0);
      chk(irq == 1, "R8 irq", {31'd0, irq}, 1);
    end

    // R12: start clears previous error
    start_job(32'h3100, 32'hA100, 32'd8, 32'h3);
    reg_read(A_STAT, v); chk(v[2:0] == 3'b001, "R12 cleared on start", v, 1);
    wait_idle();
    reg_read(A_STAT, v); chk(v[2:0] == 3'b010, "R12 job ok", v, 2);

    // R9: read error on second beat
    err_rd_addr = 32'h4004;
    start_job(32'h4000, 32'hB000, 32'd16, 32'h3);
    wait_idle();
    reg_read(A_STAT, v); chk(v[2:0] == 3'b110, "R9 read err status", v, 6);
    chk(n_rd - base_rd == 2 && n_wr - base_wr == 1, "R9 read err stop", 32'(n_rd - base_rd), 2);
    err_rd_addr = '1;
    // R9: write error on first beat
    err_wr_addr = 32'hC000;
    start_job(32'h4100, 32'hC000, 32'd16, 32'h3);
    wait_idle();
    reg_read(A_STAT, v); chk(v[2:0] == 3'b110, "R9 write err status", v, 6);
    chk(n_rd - base_rd == 1 && n_wr - base_wr == 1, "R9 write err stop", 32'(n_rd - base_rd), 1);
    err_wr_addr = '1;

    // R10: configuration and start ignored while busy
    lat = 15;
    start_job(32'h5000, 32'hD000, 32'd8, 32'h3);
    reg_write(A_SRC, 32'hDEAD_0000);
    reg_write(A_CNT, 32'd40);
    reg_write(A_CTRL, 32'h3);
    reg_read(A_SRC, v); chk(v == 32'h5000, "R10 src frozen", v, 32'h5000);
    reg_read(A_CNT, v); chk(v == 32'd8, "R10 cnt frozen", v, 8);
    wait_idle();
    chk(n_wr - base_wr == 2, "R10 beats unchanged", 32'(n_wr - base_wr), 2);
    repeat (5) @(negedge clk);
    chk(!rd_bus_req && n_rd - base_rd == 2, "R10 no restart", 32'(n_rd - base_rd), 2);
    lat = 2;

    // R11: clear write coinciding with completion
    start_job(32'h6000, 32'hE000, 32'd8, 32'h3);
    begin
      bit busy_now;
      busy_now = 1;
      while (busy_now) begin
        @(negedge clk);
        reg_addr = A_STAT; reg_wdata = 32'h2;
        #1;
        busy_now = reg_rdata[0];
        reg_wr = busy_now;
      end
      reg_wr = 0;
    end
    reg_read(A_STAT, v); chk(v[2:0] == 3'b010, "R11 completion wins", v, 2);
    chk(irq == 1, "R11 irq kept", {31'd0, irq}, 1);

    repeat (4) @(negedge clk);
    if (!wd_fail) begin
      $display("  CHECKS %0d ERRORS %0d", n_checks + m_checks, n_errors + m_errors);
      $finish;
    end
  end

endmodule